// File: doc/BRIEF.md
# In-Band Escape Command Decoder

This block sits on the byte stream that comes from a terminal. That stream carries ordinary user data, and it also carries commands that an escape byte introduces. The decoder removes the commands from the stream. It sends only clean user data out on a valid/ready port.

Each command does one of four things:
- It expands into one or two literal bytes that would otherwise be confused with the escape, and these go into the data stream.
- It sets the level of one of three terminal-driven control circuits.
- It grants or withdraws permission to send in-band commands back toward the terminal.
- It raises a one-cycle pulse for a status poll or for a vendor-defined command.

Extended commands carry a length byte. The decoder swallows the whole extended command, including any escape bytes inside it.

The parser is a five-state machine:
- `ST_DATA` passes plain bytes through. An escape byte moves it to `ST_ESC`.
- `ST_ESC` decodes the command byte. A one-byte literal, a circuit, flow, vendor, poll or unknown code returns it to `ST_DATA`. A two-byte literal moves it to `ST_DUP`. An extended code moves it to `ST_LEN`.
- `ST_DUP` holds the input until the second literal byte is in the output register. It then returns to `ST_DATA`.
- `ST_LEN` takes the length byte. It goes to `ST_DATA` if nothing remains to skip, and to `ST_SKIP` otherwise.
- `ST_SKIP` discards bytes and returns to `ST_DATA` on the last one.

Top module: `inband_cmd_parser`

## Requirements
- R1: A byte other than 0x19 accepted in `ST_DATA` appears on `out_data` unchanged, with order kept.
- R2: After the escape byte 0x19, code 0x5C emits one 0x19 data byte, and code 0x5D emits 0x19 twice.
- R3: After an escape, code 0x58 emits one 0x99 data byte, and code 0x59 emits 0x99 twice.
- R4: After an escape, codes 0x42 to 0x47 set the circuit levels. 0x42/0x43 drive `lvl_req_send`, 0x44/0x45 drive `lvl_term_ready` and 0x46/0x47 drive `lvl_rx_ready`. Bit 0 of the code gives the new level. No data byte is produced.
- R5: After an escape, code 0x5A clears `send_permit` and code 0x5B sets it.
- R6: After an escape, codes 0x20, 0x40 and 0x41 start an extended command. The next byte L is a length. A further max(L−0x1F, 0) bytes follow it. The decoder discards all of these bytes, even escape bytes, and produces no data and no pulse. It then parses normally again.
- R7: After an escape, codes 0x21 to 0x2F give a one-cycle `vend_pulse`, with `vend_code` equal to the low nibble of the code.
- R8: After an escape, code 0x5E gives a one-cycle `poll_pulse`.
- R9: Any other code after an escape sets `code_error`, which stays set until reset. Such a code produces no data.
- R10: Reset clears `out_valid`, all three circuit levels and `code_error`, and sets `send_permit`.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` holds steady. An escape byte or a non-literal code is still accepted during this time. A literal code is not accepted until the output register is free.
- R12: After a two-byte literal code is accepted, `in_ready` stays low until the second byte has been loaded into the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte from the terminal stream |
| in_ready | output | 1 | Decoder accepts the input byte this cycle |
| out_valid | output | 1 | Clean user data byte present |
| out_data | output | 8 | Clean user data byte |
| out_ready | input | 1 | Consumer takes the output byte this cycle |
| lvl_req_send | output | 1 | Level of the request-to-send circuit |
| lvl_term_ready | output | 1 | Level of the terminal-ready circuit |
| lvl_rx_ready | output | 1 | Level of the ready-for-receiving circuit |
| send_permit | output | 1 | Commands may be sent toward the terminal |
| poll_pulse | output | 1 | One-cycle status poll request |
| vend_pulse | output | 1 | One-cycle vendor command indication |
| vend_code | output | 4 | Low nibble of the last vendor command |
| code_error | output | 1 | Sticky flag for an unknown command code |

## Verification
Decoding a control command can fall in the same cycle as an earlier data byte that is still waiting in the output register.

The bench provokes this by holding `out_ready` low after a data byte is loaded. It then sends a circuit command and a poll.

It judges the result in three ways:
- The held byte must not change while the level changes and the poll pulse appears.
- A literal code sent next must see `in_ready` low until the consumer frees the register.
- Over a sweep of every code value, with `out_ready` toggling in a fixed pattern, the received data stream must match a queue of expected bytes computed in the bench.

// File: rtl/inband_pkg.sv
package inband_pkg;
    localparam int            BYTE_W     = 8;
    localparam logic [7:0]    ESC_CHAR   = 8'h19;
    localparam logic [7:0]    ALT_CHAR   = 8'h99;
    localparam logic [7:0]    LEN_OFFSET = 8'h1F;

    typedef enum logic [2:0] {
        ST_DATA,
        ST_ESC,
        ST_DUP,
        ST_LEN,
        ST_SKIP
    } parse_st_t;

    typedef enum logic [2:0] {
        CL_LIT1,
        CL_LIT2,
        CL_CIRC,
        CL_FLOW,
        CL_EXT,
        CL_VEND,
        CL_POLL,
        CL_BAD
    } cmd_cls_t;
endpackage

// File: rtl/inband_code_class.sv
module inband_code_class
    import inband_pkg::*;
(
    input  logic [BYTE_W-1:0] code,
    output cmd_cls_t          cls,
    output logic [BYTE_W-1:0] lit,
    output logic [1:0]        circ_idx,
    output logic              bit_val
);
    always_comb begin
        cls      = CL_BAD;
        lit      = ESC_CHAR;
        circ_idx = 2'd0;
        bit_val  = code[0];
        if (code == 8'h5C || code == 8'h5D) begin
            cls = code[0] ? CL_LIT2 : CL_LIT1;
            lit = ESC_CHAR;
        end else if (code == 8'h58 || code == 8'h59) begin
            cls = code[0] ? CL_LIT2 : CL_LIT1;
            lit = ALT_CHAR;
        end else if (code >= 8'h42 && code <= 8'h47) begin
            cls      = CL_CIRC;
            circ_idx = 2'((code - 8'h42) >> 1);
        end else if (code == 8'h5A || code == 8'h5B) begin
            cls = CL_FLOW;
        end else if (code == 8'h20 || code == 8'h40 || code == 8'h41) begin
            cls = CL_EXT;
        end else if (code[7:4] == 4'h2 && code[3:0] != 4'h0) begin
            cls = CL_VEND;
        end else if (code == 8'h5E) begin
            cls = CL_POLL;
        end
    end
endmodule

// File: rtl/inband_skip_cnt.sv
module inband_skip_cnt
    import inband_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [BYTE_W-1:0] len_byte,
    output logic              none,
    output logic              last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem_q;

    assign none = (len_byte <= LEN_OFFSET);
    assign last = (rem_q == ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= CNT_W'(len_byte - LEN_OFFSET);
        end else if (step && rem_q != '0) begin
            rem_q <= rem_q - ONE;
        end
    end
endmodule

// File: rtl/inband_cmd_parser.sv
module inband_cmd_parser
    import inband_pkg::*;
#(
    parameter int SKIP_CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    output logic              lvl_req_send,
    output logic              lvl_term_ready,
    output logic              lvl_rx_ready,
    output logic              send_permit,
    output logic              poll_pulse,
    output logic              vend_pulse,
    output logic [3:0]        vend_code,
    output logic              code_error
);
    localparam int N_CIRC = 3;

    parse_st_t         st_q, st_d;
    cmd_cls_t          cls;
    logic [BYTE_W-1:0] lit;
    logic [1:0]        circ_idx;
    logic              bit_val;
    logic              acc, slot_free, is_esc, lit_code;
    logic              skip_none, skip_last;

    logic              ov_q;
    logic [BYTE_W-1:0] od_q, dup_q;
    logic [N_CIRC-1:0] ckt_q;
    logic              permit_q, poll_q, vend_q, err_q;
    logic [3:0]        vcode_q;

    inband_code_class u_class (
        .code     (in_data),
        .cls      (cls),
        .lit      (lit),
        .circ_idx (circ_idx),
        .bit_val  (bit_val)
    );

    inband_skip_cnt #(.CNT_W(SKIP_CNT_W)) u_skip (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc && st_q == ST_LEN),
        .step     (acc && st_q == ST_SKIP),
        .len_byte (in_data),
        .none     (skip_none),
        .last     (skip_last)
    );

    assign slot_free = !ov_q || out_ready;
    assign is_esc    = (in_data == ESC_CHAR);
    assign lit_code  = (cls == CL_LIT1) || (cls == CL_LIT2);
    assign acc       = in_valid && in_ready;

    always_comb begin
        unique case (st_q)
            ST_DATA: in_ready = slot_free || is_esc;
            ST_ESC:  in_ready = slot_free || !lit_code;
            ST_DUP:  in_ready = 1'b0;
            ST_LEN,
            ST_SKIP: in_ready = 1'b1;
            default: in_ready = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_DATA: if (acc && is_esc) st_d = ST_ESC;
            ST_ESC: begin
                if (acc) begin
                    if (cls == CL_LIT2)     st_d = ST_DUP;
                    else if (cls == CL_EXT) st_d = ST_LEN;
                    else                    st_d = ST_DATA;
                end
            end
            ST_DUP:  if (slot_free) st_d = ST_DATA;
            ST_LEN:  if (acc) st_d = skip_none ? ST_DATA : ST_SKIP;
            ST_SKIP: if (acc && skip_last) st_d = ST_DATA;
            default: st_d = ST_DATA;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_DATA;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ov_q     <= 1'b0;
            od_q     <= '0;
            dup_q    <= '0;
            permit_q <= 1'b1;
            poll_q   <= 1'b0;
            vend_q   <= 1'b0;
            vcode_q  <= 4'h0;
            err_q    <= 1'b0;
        end else begin
            poll_q <= 1'b0;
            vend_q <= 1'b0;
            if (out_ready) ov_q <= 1'b0;
            unique case (st_q)
                ST_DATA: begin
                    if (acc && !is_esc) begin
                        ov_q <= 1'b1;
                        od_q <= in_data;
                    end
                end
                ST_ESC: begin
                    if (acc) begin
                        unique case (cls)
                            CL_LIT1: begin
                                ov_q <= 1'b1;
                                od_q <= lit;
                            end
                            CL_LIT2: begin
                                ov_q  <= 1'b1;
                                od_q  <= lit;
                                dup_q <= lit;
                            end
                            CL_FLOW: permit_q <= bit_val;
                            CL_VEND: begin
                                vend_q  <= 1'b1;
                                vcode_q <= in_data[3:0];
                            end
                            CL_POLL: poll_q <= 1'b1;
                            CL_BAD:  err_q  <= 1'b1;
                            default: ;
                        endcase
                    end
                end
                ST_DUP: begin
                    if (slot_free) begin
                        ov_q <= 1'b1;
                        od_q <= dup_q;
                    end
                end
                default: ;
            endcase
        end
    end

    for (genvar gi = 0; gi < N_CIRC; gi++) begin : g_ckt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ckt_q[gi] <= 1'b0;
            end else if (acc && st_q == ST_ESC && cls == CL_CIRC && circ_idx == 2'(gi)) begin
                ckt_q[gi] <= bit_val;
            end
        end
    end

    assign out_valid      = ov_q;
    assign out_data       = od_q;
    assign lvl_req_send   = ckt_q[0];
    assign lvl_term_ready = ckt_q[1];
    assign lvl_rx_ready   = ckt_q[2];
    assign send_permit    = permit_q;
    assign poll_pulse     = poll_q;
    assign vend_pulse     = vend_q;
    assign vend_code      = vcode_q;
    assign code_error     = err_q;

    // R11: a held output byte does not move until it is taken
    assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R12: input stalls right after a two-byte literal code
    assert_dup_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc && st_q == ST_ESC && cls == CL_LIT2 |=> !in_ready);

    // R6: bytes swallowed by an extended command never start a data byte
    assert_skip_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (st_q == ST_LEN || st_q == ST_SKIP) |=> !$rose(out_valid));

    // R7: a vendor pulse follows an accepted byte from the 0x2_ column
    assert_vend_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vend_pulse |-> $past(acc && in_data[7:4] == 4'h2));

    // R8: a poll pulse follows an accepted 0x5E
    assert_poll_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        poll_pulse |-> $past(acc && in_data == 8'h5E));

    // R9: the error flag never drops without reset
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        code_error |=> code_error);

    // R4: circuit levels move only on an accepted byte
    assert_lvl_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({lvl_req_send, lvl_term_ready, lvl_rx_ready}) |-> $past(acc));

    // R5: permission moves only on an accepted command code
    assert_permit_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(send_permit) |-> $past(acc && st_q == ST_ESC));
endmodule

// File: tb/sim_inband_cmd_parser.sv
`timescale 1ns/1ps
module sim_inband_cmd_parser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b0;
    logic       lvl_req_send, lvl_term_ready, lvl_rx_ready;
    logic       send_permit, poll_pulse, vend_pulse, code_error;
    logic [3:0] vend_code;

    always #2.5 clk = ~clk;

    inband_cmd_parser u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .lvl_req_send(lvl_req_send), .lvl_term_ready(lvl_term_ready),
        .lvl_rx_ready(lvl_rx_ready), .send_permit(send_permit),
        .poll_pulse(poll_pulse), .vend_pulse(vend_pulse),
        .vend_code(vend_code), .code_error(code_error)
    );

    int         nvec = 0;
    int         nerr = 0;
    bit         done = 1'b0;
    bit         hold_out = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    logic [7:0] q_exp[$];
    string      q_tag[$];
    int         n_poll = 0;
    int         n_vend = 0;
    logic [3:0] last_vcode = 4'h0;

    logic [2:0] m_lvl;
    logic       m_perm, m_err;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] b, input string req);
        q_exp.push_back(b);
        q_tag.push_back(req);
    endtask

    task automatic present(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
    endtask

    task automatic wait_acc();
        forever begin
            #1;
            if (in_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        present(b);
        wait_acc();
    endtask

    task automatic drain();
        for (int k = 0; k < 300 && q_exp.size() != 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        m_lvl = 3'b000; m_perm = 1'b1; m_err = 1'b0;
        chk("R10 out_valid", out_valid, 0);
        chk("R10 levels", {lvl_rx_ready, lvl_term_ready, lvl_req_send}, 0);
        chk("R10 permit", send_permit, 1);
        chk("R10 error", code_error, 0);
    endtask

    // consumer with a fixed pseudo-random ready pattern
    initial forever begin
        @(negedge clk);
        out_ready = hold_out ? 1'b0 : (lfsr[0] | lfsr[2]);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        #1;
        if (out_valid && out_ready) begin
            if (q_exp.size() == 0) begin
                chk("R1 unexpected byte", out_data, 32'hFFFF);
            end else begin
                chk(q_tag.pop_front(), out_data, q_exp.pop_front());
            end
        end
    end

    initial forever begin
        @(negedge clk);
        #2;
        if (poll_pulse) n_poll++;
        if (vend_pulse) begin
            n_vend++;
            last_vcode = vend_code;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [7:0] cd, tb, len;
        int         p0, v0, nskip;
        do_reset();

        // sweep of every code after an escape
        for (int c = 0; c < 256; c++) begin
            cd = c[7:0];
            p0 = n_poll;
            v0 = n_vend;
            send(8'h19);
            send(cd);
            if (cd == 8'h5C) expect_byte(8'h19, "R2 single");
            else if (cd == 8'h5D) begin
                expect_byte(8'h19, "R2 double a");
                expect_byte(8'h19, "R2 double b");
            end else if (cd == 8'h58) expect_byte(8'h99, "R3 single");
            else if (cd == 8'h59) begin
                expect_byte(8'h99, "R3 double a");
                expect_byte(8'h99, "R3 double b");
            end else if (cd >= 8'h42 && cd <= 8'h47) m_lvl[(c - 8'h42) / 2] = cd[0];
            else if (cd == 8'h5A || cd == 8'h5B) m_perm = cd[0];
            else if (cd == 8'h20 || cd == 8'h40 || cd == 8'h41) begin
                nskip = (c % 7) * 2;
                len = 8'(8'h1F + nskip);
                send(len);
                for (int k = 0; k < nskip; k++) send((k % 3 == 0) ? 8'h19 : 8'(8'h5D + k));
            end else if (cd[7:4] == 4'h2 && cd[3:0] != 4'h0) begin
                // vendor code, checked below
            end else if (cd == 8'h5E) begin
                // poll, checked below
            end else m_err = 1'b1;
            tb = (cd == 8'h19) ? 8'h18 : cd;
            send(tb);
            expect_byte(tb, "R1 trailer");
            drain();
            chk("R4 levels", {lvl_rx_ready, lvl_term_ready, lvl_req_send}, m_lvl);
            chk("R5 permit", send_permit, m_perm);
            chk("R8 poll count", n_poll - p0, (cd == 8'h5E) ? 1 : 0);
            chk("R7 vend count", n_vend - v0, (cd[7:4] == 4'h2 && cd[3:0] != 4'h0) ? 1 : 0);
            if (cd[7:4] == 4'h2 && cd[3:0] != 4'h0) chk("R7 vend code", last_vcode, cd[3:0]);
            chk("R9 error", code_error, m_err);
            chk("R6 queue empty", q_exp.size(), 0);
            if (m_err) begin
                repeat (3) @(negedge clk);
                chk("R9 error held", code_error, 1);
                do_reset();
            end
        end

        // length sweep of an extended command
        for (int l = 0; l <= 8'h30; l++) begin
            send(8'h19);
            send(8'h40);
            send(8'(l));
            nskip = (l > 8'h1F) ? l - 8'h1F : 0;
            for (int k = 0; k < nskip; k++) send((k % 2 == 0) ? 8'h19 : 8'h5E);
            tb = 8'(8'h50 + l % 16);
            send(tb);
            expect_byte(tb, "R6 after skip");
            drain();
            chk("R6 queue empty", q_exp.size(), 0);
            chk("R6 no error", code_error, 0);
        end

        // control decode while a data byte is held
        hold_out = 1'b1;
        p0 = n_poll;
        send(8'h41);
        expect_byte(8'h41, "R11 held byte");
        send(8'h19);
        send(8'h45);
        send(8'h19);
        send(8'h5E);
        repeat (2) @(negedge clk);
        #1;
        chk("R4 level while held", lvl_term_ready, 1);
        chk("R8 poll while held", n_poll - p0, 1);
        chk("R11 out_valid held", out_valid, 1);
        chk("R11 out_data held", out_data, 8'h41);
        send(8'h19);
        present(8'h5C);
        #1;
        chk("R11 literal stalls", in_ready, 0);
        expect_byte(8'h19, "R2 after release");
        hold_out = 1'b0;
        wait_acc();
        drain();
        chk("R11 queue empty", q_exp.size(), 0);

        // two-byte literal stall
        hold_out = 1'b1;
        send(8'h19);
        send(8'h59);
        expect_byte(8'h99, "R12 first");
        expect_byte(8'h99, "R12 second");
        present(8'h33);
        repeat (3) begin
            #1;
            chk("R12 stalled", in_ready, 0);
            @(negedge clk);
        end
        expect_byte(8'h33, "R12 next data");
        hold_out = 1'b0;
        wait_acc();
        drain();
        chk("R12 queue empty", q_exp.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule